// File: doc/BRIEF.md
# UART Modem Handshake Status and Control

This block is the modem-handshake slice of a 16550-class serial port. It takes the three active-low handshake inputs (clear-to-send, data-set-ready, carrier-detect) and passes each through a two-stage synchroniser. It shows their present levels and their change-since-last-read flags in a readable modem status register. From those flags it forms a modem-status interrupt request, which goes to a separate interrupt identification unit. It also drives the active-low data-terminal-ready output from a bit in its modem control register.

The processor reaches the block through a small register port. This port has three chip-select inputs (two active high, one active low), a register address, single-cycle read and write strobes, and byte-wide write and read data. The control register also holds a local-loop bit, which forces data-terminal-ready inactive. It holds an automatic clear-to-send flow-control bit as well. In that mode the synchronised clear-to-send level becomes a transmit-permit output for the transmitter. A clear-to-send change then no longer raises the interrupt.

Top module: `uart_modem_ctl`

## Requirements
- R1: The register port responds only when `cs_hi_a` and `cs_hi_b` are both 1 and `cs_lo_n` is 0. With any other select combination a write changes no register, and a read returns `rd_data` = 0x00.
- R2: Reading the status register (address 6) returns the active-high sense of the pins. Bit 4 is 1 while `cts_n` is low, bit 5 is 1 while `dsr_n` is low and bit 7 is 1 while `dcd_n` is low. Bits 2 and 6 always read 0. A pin change shows in these bits within three clock edges.
- R3: Status bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier-detect) become 1 when the synchronised level of that input changes in either direction. They stay 1 until the status register is read.
- R4: A status register read returns the flags as they were, then clears bits 0, 1 and 3. A change detected in the same cycle as the read sets its flag again, so it shows on the next read.
- R5: `msi_req` is 1 while the interrupt-enable register (address 1) bit 3 is set and the data-set-ready or carrier-detect change flag is set. It is 0 while bit 3 is clear.
- R6: With enable bit 3 set, a clear-to-send change flag raises `msi_req` only while the automatic flow-control bit (control register bit 5) is 0.
- R7: `tx_permit` is 1 while control bit 5 is 0. While bit 5 is 1, `tx_permit` is 1 exactly when the synchronised `cts_n` is low.
- R8: `dtr_n` is 0 while control register (address 4) bit 0 is 1 and loop bit 4 is 0. Otherwise it is 1.
- R9: While `mr` is high, the control and enable registers and all change flags are cleared, `dtr_n` is 1, `msi_req` is 0 and `tx_permit` is 1.
- R10: The control register reads back bits 0, 4 and 5 as written, with the other bits 0. The enable register reads back bit 3, with the other bits 0. Reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mr | input | 1 | Master reset, active high, asynchronous |
| cs_hi_a | input | 1 | Chip select, active high |
| cs_hi_b | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| reg_addr | input | 3 | Register address |
| rd_stb | input | 1 | Register read strobe, one cycle per access |
| wr_stb | input | 1 | Register write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid while a selected read is active |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| tx_permit | output | 1 | Transmitter permission under automatic flow control |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
The change detector is driven in several ways: single-pin falls and rises, with the interrupt enable off and then on, and a pin change timed to arrive in the very cycle of a status read. Together these separate a flag that is lost, one that never clears, and one that clears too early. Clear-to-send toggles run with automatic flow control on and then off, which shows whether the interrupt masking and the transmit-permit path follow that bit. Writes and reads with a deselected chip-select set and with the loop bit set check the decode and the data-terminal-ready override. A mid-test master reset checks that every register returns to its cleared state.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;

    localparam int unsigned N_MODEM = 3;
    localparam int unsigned IDX_CTS = 0;
    localparam int unsigned IDX_DSR = 1;
    localparam int unsigned IDX_DCD = 2;

    typedef struct packed {
        logic dtr;
        logic loop_en;
        logic auto_cts;
        logic msi_en;
    } mdm_ctl_t;

    typedef struct packed {
        logic [N_MODEM-1:0] prev;
        logic [N_MODEM-1:0] chg;
    } mdm_stat_t;

    function automatic logic [7:0] pack_msr(input logic [N_MODEM-1:0] lvl,
                                            input logic [N_MODEM-1:0] chg);
        logic [7:0] v;
        v = '0;
        v[0] = chg[IDX_CTS];
        v[1] = chg[IDX_DSR];
        v[3] = chg[IDX_DCD];
        v[4] = lvl[IDX_CTS];
        v[5] = lvl[IDX_DSR];
        v[7] = lvl[IDX_DCD];
        return v;
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] in_async,
    output logic [WIDTH-1:0] out_sync
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], in_async[i]};
        end

        always_ff @(posedge clk or posedge rst) begin
            if (rst) chain_q <= '0;
            else     chain_q <= chain_d;
        end

        assign out_sync[i] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/mdm_status.sv
module mdm_status
    import uart_mdm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_MODEM-1:0] lvl,
    input  logic               msr_rd,
    input  logic               msi_en,
    input  logic               auto_cts,
    output logic [7:0]         msr,
    output logic               msi_req
);

    mdm_stat_t          st_d;
    mdm_stat_t          st_q;
    logic [N_MODEM-1:0] edge_now;

    always_comb begin
        edge_now = lvl ^ st_q.prev;
        st_d.prev = lvl;
        st_d.chg  = (msr_rd ? '0 : st_q.chg) | edge_now;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign msr     = pack_msr(lvl, st_q.chg);
    assign msi_req = msi_en & (st_q.chg[IDX_DSR] | st_q.chg[IDX_DCD] |
                               (st_q.chg[IDX_CTS] & ~auto_cts));

    // R3
    chg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!msr_rd) |=> ((st_q.chg & $past(st_q.chg)) == $past(st_q.chg)));

    // R4
    chg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (msr_rd && (lvl == st_q.prev)) |=> (st_q.chg == '0));

    // R3
    chg_detect_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl != st_q.prev) |=> ((st_q.chg & $past(lvl ^ st_q.prev)) == $past(lvl ^ st_q.prev)));

endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
    import uart_mdm_pkg::*;
#(
    parameter int unsigned ADDR_W       = 3,
    parameter int unsigned IER_ADDR     = 1,
    parameter int unsigned MCR_ADDR     = 4,
    parameter int unsigned MSR_ADDR     = 6,
    parameter int unsigned IER_MSI_BIT  = 3,
    parameter int unsigned MCR_DTR_BIT  = 0,
    parameter int unsigned MCR_LOOP_BIT = 4,
    parameter int unsigned MCR_AUTO_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_hi_a,
    input  logic              cs_hi_b,
    input  logic              cs_lo_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [7:0]        wdata,
    input  logic [7:0]        msr_in,
    output logic [7:0]        rdata,
    output logic              msr_rd,
    output mdm_ctl_t          ctl
);

    localparam logic [7:0] USED_MASK = 8'((1 << MCR_DTR_BIT) | (1 << MCR_LOOP_BIT) |
                                          (1 << MCR_AUTO_BIT) | (1 << IER_MSI_BIT));

    mdm_ctl_t ctl_d;
    mdm_ctl_t ctl_q;
    logic     picked;
    logic     wr_mcr;
    logic     wr_ier;
    logic     unused_wdata;

    assign picked       = cs_hi_a & cs_hi_b & ~cs_lo_n;
    assign wr_mcr       = picked & wr_stb & (addr == ADDR_W'(MCR_ADDR));
    assign wr_ier       = picked & wr_stb & (addr == ADDR_W'(IER_ADDR));
    assign msr_rd       = picked & rd_stb & (addr == ADDR_W'(MSR_ADDR));
    assign unused_wdata = ^(wdata & ~USED_MASK);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_mcr) begin
            ctl_d.dtr      = wdata[MCR_DTR_BIT];
            ctl_d.loop_en  = wdata[MCR_LOOP_BIT];
            ctl_d.auto_cts = wdata[MCR_AUTO_BIT];
        end
        if (wr_ier) begin
            ctl_d.msi_en = wdata[IER_MSI_BIT];
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    always_comb begin
        rdata = '0;
        if (picked && rd_stb) begin
            if (addr == ADDR_W'(MSR_ADDR)) begin
                rdata = msr_in;
            end else if (addr == ADDR_W'(MCR_ADDR)) begin
                rdata[MCR_DTR_BIT]  = ctl_q.dtr;
                rdata[MCR_LOOP_BIT] = ctl_q.loop_en;
                rdata[MCR_AUTO_BIT] = ctl_q.auto_cts;
            end else if (addr == ADDR_W'(IER_ADDR)) begin
                rdata[IER_MSI_BIT] = ctl_q.msi_en;
            end
        end
    end

    assign ctl = ctl_q;

    // R1
    unselected_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !(cs_hi_a && cs_hi_b && !cs_lo_n)) |=> $stable(ctl_q));

    // R1
    unselected_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_hi_a || !cs_hi_b || cs_lo_n) |-> (rdata == 8'h00));

endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import uart_mdm_pkg::*;
#(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              mr,
    input  logic              cs_hi_a,
    input  logic              cs_hi_b,
    input  logic              cs_lo_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              dcd_n,
    output logic              dtr_n,
    output logic              tx_permit,
    output logic              msi_req
);

    localparam int unsigned MCR_ADDR = 4;

    logic [N_MODEM-1:0] pin_active;
    logic [N_MODEM-1:0] lvl;
    logic [7:0]         msr;
    logic               msr_rd;
    mdm_ctl_t           ctl;

    always_comb begin
        pin_active          = '0;
        pin_active[IDX_CTS] = ~cts_n;
        pin_active[IDX_DSR] = ~dsr_n;
        pin_active[IDX_DCD] = ~dcd_n;
    end

    mdm_sync #(.WIDTH(N_MODEM), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (mr),
        .in_async (pin_active),
        .out_sync (lvl)
    );

    mdm_status status_i (
        .clk      (clk),
        .rst      (mr),
        .lvl      (lvl),
        .msr_rd   (msr_rd),
        .msi_en   (ctl.msi_en),
        .auto_cts (ctl.auto_cts),
        .msr      (msr),
        .msi_req  (msi_req)
    );

    mdm_regs #(.ADDR_W(ADDR_W), .MCR_ADDR(MCR_ADDR)) regs_i (
        .clk     (clk),
        .rst     (mr),
        .cs_hi_a (cs_hi_a),
        .cs_hi_b (cs_hi_b),
        .cs_lo_n (cs_lo_n),
        .addr    (reg_addr),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .wdata   (wr_data),
        .msr_in  (msr),
        .rdata   (rd_data),
        .msr_rd  (msr_rd),
        .ctl     (ctl)
    );

    assign dtr_n     = ~(ctl.dtr & ~ctl.loop_en);
    assign tx_permit = ~ctl.auto_cts | lvl[IDX_CTS];

    // R8
    dtr_drive_chk: assert property (@(posedge clk) disable iff (mr)
        (cs_hi_a && cs_hi_b && !cs_lo_n && wr_stb && reg_addr == ADDR_W'(MCR_ADDR) &&
         wr_data[0] && !wr_data[4]) |=> !dtr_n);

    // R8
    dtr_loop_chk: assert property (@(posedge clk) disable iff (mr)
        (cs_hi_a && cs_hi_b && !cs_lo_n && wr_stb && reg_addr == ADDR_W'(MCR_ADDR) &&
         wr_data[4]) |=> dtr_n);

    // R6
    cts_mask_chk: assert property (@(posedge clk) disable iff (mr)
        (msi_req && ctl.auto_cts) |-> (msr[1] || msr[3]));

    // R5
    msi_source_chk: assert property (@(posedge clk) disable iff (mr)
        msi_req |-> ((msr[0] || msr[1] || msr[3]) && ctl.msi_en));

endmodule

// File: tb/uart_modem_ctl_tb_top.sv
module uart_modem_ctl_tb_top;

    logic       clk = 1'b0;
    logic       mr = 1'b1;
    logic       cs_hi_a = 1'b1;
    logic       cs_hi_b = 1'b1;
    logic       cs_lo_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       cts_n = 1'b1;
    logic       dsr_n = 1'b1;
    logic       dcd_n = 1'b1;
    logic       dtr_n;
    logic       tx_permit;
    logic       msi_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    uart_modem_ctl dut_i (
        .clk       (clk),
        .mr        (mr),
        .cs_hi_a   (cs_hi_a),
        .cs_hi_b   (cs_hi_b),
        .cs_lo_n   (cs_lo_n),
        .reg_addr  (reg_addr),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .cts_n     (cts_n),
        .dsr_n     (dsr_n),
        .dcd_n     (dcd_n),
        .dtr_n     (dtr_n),
        .tx_permit (tx_permit),
        .msi_req   (msi_req)
    );

    // monitor: compare read data against the scoreboard queue
    always @(negedge clk) begin
        if (rd_stb && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rd_data !== e) begin
                n_fail++;
                $display("FAIL %s rd_data=%02h expected %02h", t, rd_data, e);
            end
        end
    end

    task automatic set_sel(input bit on);
        cs_hi_a = on;
        cs_hi_b = on;
        cs_lo_n = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a;
        wr_data  = d;
        wr_stb   = 1'b1;
        @(posedge clk); #2;
        wr_stb   = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        reg_addr = a;
        rd_stb   = 1'b1;
        @(posedge clk); #2;
        rd_stb   = 1'b0;
    endtask

    task automatic pin_check(input string t, input logic act, input logic e);
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s actual=%b expected %b", t, act, e);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R9 reset state
        pin_check("R9 dtr_n in reset", dtr_n, 1'b1);
        pin_check("R9 msi_req in reset", msi_req, 1'b0);
        mr = 1'b0;
        @(posedge clk); #2;
        pin_check("R7 tx_permit after reset", tx_permit, 1'b1);
        rd(3'd6, 8'h00, "R2 status after reset");
        rd(3'd4, 8'h00, "R10 control after reset");

        // R8 data-terminal-ready
        wr(3'd4, 8'h01);
        pin_check("R8 dtr_n asserted", dtr_n, 1'b0);
        rd(3'd4, 8'h01, "R10 control readback");
        wr(3'd4, 8'h11);
        pin_check("R8 loop forces dtr_n high", dtr_n, 1'b1);
        rd(3'd4, 8'h11, "R10 control loop readback");
        wr(3'd4, 8'hCF);
        rd(3'd4, 8'h01, "R10 control unused bits");
        pin_check("R8 dtr_n after loop cleared", dtr_n, 1'b0);
        rd(3'd2, 8'h00, "R10 other address");

        // R1 deselected access
        cs_hi_b = 1'b0;
        wr(3'd4, 8'h00);
        cs_hi_b = 1'b1;
        pin_check("R1 deselected write ignored", dtr_n, 1'b0);
        cs_lo_n = 1'b1;
        rd(3'd4, 8'h00, "R1 deselected read");
        set_sel(1'b1);
        rd(3'd4, 8'h01, "R1 control kept");

        // R2 R3 R5 data-set-ready with interrupt disabled
        dsr_n = 1'b0;
        settle();
        pin_check("R5 no request while disabled", msi_req, 1'b0);
        rd(3'd6, 8'h22, "R3 dsr change");
        rd(3'd6, 8'h20, "R4 flags cleared");

        // R5 carrier-detect with interrupt enabled
        wr(3'd1, 8'hFF);
        rd(3'd1, 8'h08, "R10 enable readback");
        dcd_n = 1'b0;
        settle();
        pin_check("R5 request on dcd change", msi_req, 1'b1);
        rd(3'd6, 8'hA8, "R2 dcd level and flag");
        pin_check("R4 request cleared by read", msi_req, 1'b0);

        // R6 R7 automatic flow control
        wr(3'd4, 8'h21);
        pin_check("R7 permit low with cts inactive", tx_permit, 1'b0);
        cts_n = 1'b0;
        settle();
        pin_check("R7 permit high with cts active", tx_permit, 1'b1);
        pin_check("R6 cts change masked", msi_req, 1'b0);
        rd(3'd6, 8'hB1, "R6 cts flag still recorded");
        wr(3'd4, 8'h01);
        pin_check("R7 permit high in normal mode", tx_permit, 1'b1);
        cts_n = 1'b1;
        settle();
        pin_check("R7 permit ignores cts in normal mode", tx_permit, 1'b1);
        pin_check("R6 cts change raises request", msi_req, 1'b1);
        rd(3'd6, 8'hA1, "R6 cts flag");

        // R4 change coinciding with read
        dsr_n = 1'b1;
        @(posedge clk); #2;
        @(posedge clk); #2;
        rd(3'd6, 8'h80, "R4 read in change cycle");
        pin_check("R4 coinciding change kept request", msi_req, 1'b1);
        rd(3'd6, 8'h82, "R4 coinciding change flag");

        // R9 master reset mid-run
        dcd_n = 1'b1;
        settle();
        mr = 1'b1;
        @(posedge clk); #2;
        pin_check("R9 dtr_n high under reset", dtr_n, 1'b1);
        pin_check("R9 msi_req low under reset", msi_req, 1'b0);
        pin_check("R9 tx_permit high under reset", tx_permit, 1'b1);
        mr = 1'b0;
        @(posedge clk); #2;
        rd(3'd4, 8'h00, "R9 control cleared");
        rd(3'd1, 8'h00, "R9 enable cleared");
        rd(3'd6, 8'h00, "R9 flags cleared");

        @(posedge clk); #2;
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired, actual=%0d cycles expected completion", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule